// File: doc/BRIEF.md
# Protected Command Sequence Decoder

This block sits behind the bus front end of a flash bank and watches every write cycle the host issues to it. Altering the array is only allowed after a fixed unlock handshake: two writes of fixed data to two fixed addresses, followed by a command byte. The decoder walks this handshake in a small state machine. When a sequence completes it emits one single-cycle request for the program/erase engine or for the identification logic. The possible requests are byte program, sector erase, whole-bank erase, ID-mode entry and ID-mode exit.

Only the low 15 address bits take part in the unlock comparisons. Any write that breaks a sequence sends the machine back to read mode. While the engine reports busy, the decoder ignores every write completely. The decoder also keeps a flag that says whether ID mode is active.

Top module: `prot_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, all request outputs and `id_mode` are low. A sequence that was partly entered before reset is forgotten.
- R2: A request output goes high in the clock cycle that follows the accepted write that completes its sequence. It stays high for that one cycle only. At most one request output is high in any cycle.
- R3: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 arm a byte program. The next accepted write of any address and data raises `prog_req`. In that same cycle `prog_addr` and `prog_data` show the address and data of that write.
- R4: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, followed by 0x30 written to any address, raise `sect_req`. `sect_num` then equals bits 17:12 of the sixth write's address.
- R5: The same five erase-prefix writes followed by 0x10 at 0x5555 raise `bank_req`. A sixth write of 0x10 at any other address raises no request.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555 raise `id_enter`, and `id_mode` is high from that same cycle on.
- R7: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555 raise `id_exit` and clear `id_mode` in that cycle. So does a single write of 0xF0 to any address while no sequence is in progress.
- R8: Address bits 17:15 do not affect the unlock and command comparisons.
- R9: A write that does not match the expected address/data pair raises no request and returns the decoder to read mode. The next writes must restart from the first unlock cycle. The one exception is a breaking write that is itself 0xAA at 0x5555, which counts as the first unlock cycle.
- R10: A write accepted while `busy` is high raises no request, does not change `id_mode`, and leaves the progress of the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe marking a flash write cycle |
| wr_addr | input | 18 | Address of the write |
| wr_data | input | 8 | Data of the write |
| busy | input | 1 | Program/erase engine is running an internal operation |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | 18 | Target address of the program request |
| prog_data | output | 8 | Byte to program |
| sect_req | output | 1 | Sector erase request pulse |
| sect_num | output | 6 | Sector selected for erase |
| bank_req | output | 1 | Whole-bank erase request pulse |
| id_enter | output | 1 | ID-mode entry pulse |
| id_exit | output | 1 | ID-mode exit / reset pulse |
| id_mode | output | 1 | ID mode is active |

## Verification
The bench feeds unlock cycles whose upper address bits are set, to catch a decoder that compares the full address. It also writes 0x10 to the wrong address in the sixth cycle, where a lax decoder would erase the whole bank. Repeated 0xAA@0x5555 writes probe the restart rule: a decoder that returns to idle without reinterpreting the breaking write would miss the program that follows. Writes are issued while `busy` is high, both mid-sequence and as a bare 0xF0. A design that lets them through would either advance the sequence or drop ID mode early. Other tests check that a reset in mid-sequence forgets the sequence, and that requests last exactly one cycle.

// File: rtl/pcsd_pkg.sv
package pcsd_pkg;

   localparam int KEY_AW = 15;
   localparam int KEY_DW = 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_PARM, ST_ERA3, ST_ERA4, ST_ERA5
   } seq_st_e;

   typedef enum logic [2:0] {
      OP_NONE, OP_PROG, OP_SECT, OP_BANK, OP_IDIN, OP_IDOUT
   } op_e;

   typedef struct packed {
      logic              chk_adr;
      logic [KEY_AW-1:0] adr;
      logic [KEY_DW-1:0] dat;
   } key_t;

   // key indices
   localparam int K_AA_LO   = 0;
   localparam int K_55_HI   = 1;
   localparam int K_A0_LO   = 2;
   localparam int K_80_LO   = 3;
   localparam int K_90_LO   = 4;
   localparam int K_F0_LO   = 5;
   localparam int K_10_LO   = 6;
   localparam int K_30_ANY  = 7;
   localparam int K_F0_ANY  = 8;
   localparam int NKEY      = 9;

   localparam logic [KEY_AW-1:0] ADR_LO = 15'h5555;
   localparam logic [KEY_AW-1:0] ADR_HI = 15'h2AAA;

   function automatic key_t key_of(input int idx);
      key_t k;
      case (idx)
         K_AA_LO:  k = '{1'b1, ADR_LO, 8'hAA};
         K_55_HI:  k = '{1'b1, ADR_HI, 8'h55};
         K_A0_LO:  k = '{1'b1, ADR_LO, 8'hA0};
         K_80_LO:  k = '{1'b1, ADR_LO, 8'h80};
         K_90_LO:  k = '{1'b1, ADR_LO, 8'h90};
         K_F0_LO:  k = '{1'b1, ADR_LO, 8'hF0};
         K_10_LO:  k = '{1'b1, ADR_LO, 8'h10};
         K_30_ANY: k = '{1'b0, '0,     8'h30};
         default:  k = '{1'b0, '0,     8'hF0};
      endcase
      return k;
   endfunction

endpackage

// File: rtl/pcsd_key_match.sv
module pcsd_key_match
   import pcsd_pkg::*;
#(
   parameter key_t KEY = '0
) (
   input  logic [KEY_AW-1:0] cmp_adr,
   input  logic [KEY_DW-1:0] cmp_dat,
   output logic              hit
);

   logic adr_ok;

   generate
      if (KEY.chk_adr) begin : g_adr
         assign adr_ok = (cmp_adr == KEY.adr);
      end else begin : g_any
         assign adr_ok = 1'b1;
      end
   endgenerate

   assign hit = adr_ok && (cmp_dat == KEY.dat);

endmodule

// File: rtl/pcsd_seq.sv
module pcsd_seq
   import pcsd_pkg::*;
#(
   parameter bit LOOSE_EXIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_take,
   input  logic [NKEY-1:0] hits,
   output op_e             op_nxt
);

   seq_st_e st_q, st_d;
   logic    bare_exit;
   logic    restart;

   generate
      if (LOOSE_EXIT) begin : g_loose
         assign bare_exit = hits[K_F0_ANY];
      end else begin : g_strict
         assign bare_exit = 1'b0;
      end
   endgenerate

   assign restart = hits[K_AA_LO];

   always_comb begin
      st_d   = st_q;
      op_nxt = OP_NONE;
      if (wr_take) begin
         case (st_q)
            ST_IDLE: begin
               if (hits[K_AA_LO])  st_d = ST_UNL1;
               else if (bare_exit) op_nxt = OP_IDOUT;
            end
            ST_UNL1: begin
               if (hits[K_55_HI]) st_d = ST_UNL2;
               else               st_d = restart ? ST_UNL1 : ST_IDLE;
            end
            ST_UNL2: begin
               if (hits[K_A0_LO])      st_d = ST_PARM;
               else if (hits[K_80_LO]) st_d = ST_ERA3;
               else if (hits[K_90_LO]) begin
                  st_d   = ST_IDLE;
                  op_nxt = OP_IDIN;
               end else if (hits[K_F0_LO]) begin
                  st_d   = ST_IDLE;
                  op_nxt = OP_IDOUT;
               end else st_d = restart ? ST_UNL1 : ST_IDLE;
            end
            ST_PARM: begin
               st_d   = ST_IDLE;
               op_nxt = OP_PROG;
            end
            ST_ERA3: begin
               st_d = hits[K_AA_LO] ? ST_ERA4 : ST_IDLE;
            end
            ST_ERA4: begin
               if (hits[K_55_HI]) st_d = ST_ERA5;
               else               st_d = restart ? ST_UNL1 : ST_IDLE;
            end
            ST_ERA5: begin
               if (hits[K_10_LO]) begin
                  st_d   = ST_IDLE;
                  op_nxt = OP_BANK;
               end else if (hits[K_30_ANY]) begin
                  st_d   = ST_IDLE;
                  op_nxt = OP_SECT;
               end else st_d = restart ? ST_UNL1 : ST_IDLE;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/pcsd_req_stage.sv
module pcsd_req_stage
   import pcsd_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int SECT_LSB = 12,
   localparam int SECT_W  = ADDR_W - SECT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op_nxt,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              sect_req,
   output logic [SECT_W-1:0] sect_num,
   output logic              bank_req,
   output logic              id_enter,
   output logic              id_exit,
   output logic              id_mode
);

   op_e op_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q      <= OP_NONE;
         prog_addr <= '0;
         prog_data <= '0;
         sect_num  <= '0;
         id_mode   <= 1'b0;
      end else begin
         op_q <= op_nxt;
         if (op_nxt == OP_PROG) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (op_nxt == OP_SECT) sect_num <= wr_addr[ADDR_W-1:SECT_LSB];
         if (op_nxt == OP_IDIN)       id_mode <= 1'b1;
         else if (op_nxt == OP_IDOUT) id_mode <= 1'b0;
      end
   end

   assign prog_req = (op_q == OP_PROG);
   assign sect_req = (op_q == OP_SECT);
   assign bank_req = (op_q == OP_BANK);
   assign id_enter = (op_q == OP_IDIN);
   assign id_exit  = (op_q == OP_IDOUT);

endmodule

// File: rtl/prot_cmd_decoder.sv
module prot_cmd_decoder
   import pcsd_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int DATA_W     = 8,
   parameter int SECT_LSB   = 12,
   parameter bit LOOSE_EXIT = 1'b1,
   localparam int SECT_W    = ADDR_W - SECT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              sect_req,
   output logic [SECT_W-1:0] sect_num,
   output logic              bank_req,
   output logic              id_enter,
   output logic              id_exit,
   output logic              id_mode
);

   generate
      if (ADDR_W < KEY_AW) begin : g_bad_aw
         $error("ADDR_W must cover the compared address bits");
      end
      if (DATA_W != KEY_DW) begin : g_bad_dw
         $error("DATA_W must equal the command byte width");
      end
      if (SECT_LSB >= ADDR_W || SECT_LSB < 1) begin : g_bad_sect
         $error("SECT_LSB out of range");
      end
   endgenerate

   logic [NKEY-1:0] hits;
   logic            wr_take;
   op_e             op_nxt;

   assign wr_take = wr_valid && !busy;

   for (genvar k = 0; k < NKEY; k++) begin : g_key
      pcsd_key_match #(.KEY(key_of(k))) u_match (
         .cmp_adr (wr_addr[KEY_AW-1:0]),
         .cmp_dat (wr_data),
         .hit     (hits[k])
      );
   end

   pcsd_seq #(.LOOSE_EXIT(LOOSE_EXIT)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_take (wr_take),
      .hits    (hits),
      .op_nxt  (op_nxt)
   );

   pcsd_req_stage #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SECT_LSB (SECT_LSB)
   ) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_nxt    (op_nxt),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .prog_req  (prog_req),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .sect_req  (sect_req),
      .sect_num  (sect_num),
      .bank_req  (bank_req),
      .id_enter  (id_enter),
      .id_exit   (id_exit),
      .id_mode   (id_mode)
   );

endmodule

// File: rtl/pcsd_chk.sv
module pcsd_chk #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int SECT_LSB = 12,
   localparam int SECT_W  = ADDR_W - SECT_LSB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              busy,
   input logic              prog_req,
   input logic [ADDR_W-1:0] prog_addr,
   input logic [DATA_W-1:0] prog_data,
   input logic              sect_req,
   input logic [SECT_W-1:0] sect_num,
   input logic              bank_req,
   input logic              id_enter,
   input logic              id_exit,
   input logic              id_mode
);

   logic any_req;
   assign any_req = prog_req | sect_req | bank_req | id_enter | id_exit;

   // R2
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_req, sect_req, bank_req, id_enter, id_exit}));

   // R2
   req_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !any_req);

   // R10
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && busy) |=> !any_req);

   // R10
   busy_id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && busy) |=> $stable(id_mode));

   // R3
   prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

   // R4
   sect_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sect_req |-> (sect_num == $past(wr_addr[ADDR_W-1:SECT_LSB])));

   // R6
   id_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> id_enter);

   // R6
   id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_enter |-> id_mode);

   // R7
   id_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_exit |-> !id_mode);

endmodule

bind prot_cmd_decoder pcsd_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .SECT_LSB (SECT_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .busy      (busy),
   .prog_req  (prog_req),
   .prog_addr (prog_addr),
   .prog_data (prog_data),
   .sect_req  (sect_req),
   .sect_num  (sect_num),
   .bank_req  (bank_req),
   .id_enter  (id_enter),
   .id_exit   (id_exit),
   .id_mode   (id_mode)
);

// File: tb/prot_cmd_decoder_test.sv
`timescale 1ns/1ps
module prot_cmd_decoder_test;

   localparam int AW = 18;
   localparam int DW = 8;
   localparam int VW = 1 + AW + DW + 3 + 1;
   // result codes seen by the bench
   localparam logic [2:0] C_NO = 3'd0, C_PG = 3'd1, C_SE = 3'd2, C_BE = 3'd3,
                          C_IN = 3'd4, C_OUT = 3'd5;

   function automatic logic [VW-1:0] mk(input logic b, input logic [AW-1:0] a,
                                        input logic [DW-1:0] d, input logic [2:0] c,
                                        input logic id);
      return {b, a, d, c, id};
   endfunction

   localparam int NV = 56;
   localparam logic [VW-1:0] VEC [NV] = '{
      // R3 byte program
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'hA0, C_NO, 0), mk(0, 18'h21234, 8'h3C, C_PG, 0),
      // R8 upper address bits set during unlock
      mk(0, 18'h3D555, 8'hAA, C_NO, 0), mk(0, 18'h1AAAA, 8'h55, C_NO, 0),
      mk(0, 18'h25555, 8'hA0, C_NO, 0), mk(0, 18'h3FFFF, 8'h00, C_PG, 0),
      // R4 sector erase
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h80, C_NO, 0), mk(0, 18'h05555, 8'hAA, C_NO, 0),
      mk(0, 18'h02AAA, 8'h55, C_NO, 0), mk(0, 18'h2B000, 8'h30, C_SE, 0),
      // R5 bank erase
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h80, C_NO, 0), mk(0, 18'h05555, 8'hAA, C_NO, 0),
      mk(0, 18'h02AAA, 8'h55, C_NO, 0), mk(0, 18'h05555, 8'h10, C_BE, 0),
      // R5 bank erase at wrong address, then R9 the decoder is back in read mode
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h80, C_NO, 0), mk(0, 18'h05555, 8'hAA, C_NO, 0),
      mk(0, 18'h02AAA, 8'h55, C_NO, 0), mk(0, 18'h05556, 8'h10, C_NO, 0),
      mk(0, 18'h2B000, 8'h30, C_NO, 0),
      // R6 entry, R7 bare exit, R6 entry, R7 sequenced exit
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h90, C_IN, 1), mk(0, 18'h01234, 8'hF0, C_OUT, 0),
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h90, C_IN, 1), mk(0, 18'h05555, 8'hAA, C_NO, 1),
      mk(0, 18'h02AAA, 8'h55, C_NO, 1), mk(0, 18'h05555, 8'hF0, C_OUT, 0),
      // R9 mismatch in second cycle aborts
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h54, C_NO, 0),
      mk(0, 18'h05555, 8'hA0, C_NO, 0), mk(0, 18'h00100, 8'h11, C_NO, 0),
      // R9 a breaking AA@5555 restarts the sequence
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h05555, 8'hAA, C_NO, 0),
      mk(0, 18'h02AAA, 8'h55, C_NO, 0), mk(0, 18'h05555, 8'hA0, C_NO, 0),
      mk(0, 18'h00010, 8'h77, C_PG, 0),
      // R10 busy write mid-sequence is ignored and progress is kept
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(1, 18'h05555, 8'hA0, C_NO, 0), mk(0, 18'h05555, 8'hA0, C_NO, 0),
      mk(0, 18'h00020, 8'h5A, C_PG, 0),
      // R10 busy bare exit keeps ID mode
      mk(0, 18'h05555, 8'hAA, C_NO, 0), mk(0, 18'h02AAA, 8'h55, C_NO, 0),
      mk(0, 18'h05555, 8'h90, C_IN, 1), mk(1, 18'h00000, 8'hF0, C_NO, 1),
      mk(0, 18'h00000, 8'hF0, C_OUT, 0)
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic          prog_req, sect_req, bank_req, id_enter, id_exit, id_mode;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;
   logic [5:0]    sect_num;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prot_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr),
      .prog_data(prog_data), .sect_req(sect_req), .sect_num(sect_num),
      .bank_req(bank_req), .id_enter(id_enter), .id_exit(id_exit), .id_mode(id_mode)
   );

   function automatic logic [2:0] seen();
      int n = int'(prog_req) + int'(sect_req) + int'(bank_req) + int'(id_enter) + int'(id_exit);
      if (n > 1)    return 3'd7;
      if (prog_req) return C_PG;
      if (sect_req) return C_SE;
      if (bank_req) return C_BE;
      if (id_enter) return C_IN;
      if (id_exit)  return C_OUT;
      return C_NO;
   endfunction

   function automatic string tag_of(input logic [2:0] c, input logic b);
      if (b) return "R10";
      case (c)
         C_PG: return "R3";  C_SE: return "R4";  C_BE: return "R5";
         C_IN: return "R6";  C_OUT: return "R7"; default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive one write; on return the outputs for it are settled
   task automatic wr(input logic b, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      busy = b; wr_addr = a; wr_data = d; wr_valid = 1'b1;
      @(posedge clk);
      #2;
      wr_valid = 1'b0; busy = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check(seen() == C_NO && !id_mode, "R1", "reset outputs",
            {28'd0, seen(), id_mode}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic          vb;
         logic [AW-1:0] va;
         logic [DW-1:0] vd;
         logic [2:0]    vc;
         logic          vi;
         bit            ok;
         {vb, va, vd, vc, vi} = VEC[i];
         wr(vb, va, vd);
         ok = (seen() == vc) && (id_mode == vi);
         if (vc == C_PG) ok = ok && prog_addr == va && prog_data == vd;
         if (vc == C_SE) ok = ok && sect_num == va[17:12];
         check(ok, tag_of(vc, vb), $sformatf("vector %0d code/id/payload", i),
               {seen(), id_mode, prog_addr, prog_data[3:0], sect_num[5:0]},
               {vc, vi, (vc == C_PG) ? va : prog_addr, (vc == C_PG) ? vd[3:0] : prog_data[3:0],
                (vc == C_SE) ? va[17:12] : sect_num});
      end

      // R2 pulse lasts one cycle
      wr(0, 18'h05555, 8'hAA); wr(0, 18'h02AAA, 8'h55); wr(0, 18'h05555, 8'hA0);
      wr(0, 18'h00444, 8'h99);
      check(prog_req, "R2", "program pulse present", {31'd0, prog_req}, 32'd1);
      @(posedge clk); #2;
      check(seen() == C_NO, "R2", "pulse gone next cycle", {29'd0, seen()}, 32'd0);

      // R1 reset in mid-sequence forgets progress
      wr(0, 18'h05555, 8'hAA); wr(0, 18'h02AAA, 8'h55);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      wr(0, 18'h05555, 8'hA0);
      wr(0, 18'h00555, 8'h12);
      check(seen() == C_NO, "R1", "no program after reset", {29'd0, seen()}, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule